// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This unit carries out one indivisible read-modify-write on a 32-bit or 64-bit memory word. A request gives an operation code, an access size, a base register value, a signed 16-bit displacement, the source register value and the value of register zero. The unit adds the displacement to the base to form the byte address. It reads the old word through a simple single-port memory handshake. It then computes the new word and, when the operation calls for it, writes the new word back to the same address.

The result comes back as a one-cycle response. The response can carry a write to the source register holding the old memory value. For compare-and-swap it instead carries a write to register zero. The unit accepts no further request from the first memory access until the response has been given. Two accesses from the same operation therefore never interleave with those of another. Bad codes, bad sizes and misaligned addresses are rejected with an error flag before any memory traffic.

Top module: `amo_unit`

## Requirements
- R1: The memory address is `req_base` plus `req_offset` sign-extended to 64 bits. Both the read and the write of an operation use this address, and it stays stable while `mem_req` is high.
- R2: Size code 2 selects a 32-bit access and size code 3 selects a 64-bit access. A 32-bit operation uses only the low 32 bits of the source, of register zero and of the stored word, and every value it returns is zero-extended.
- R3: Size codes 0 and 1 raise `resp_err`. They cause no memory access and no register write.
- R4: An address that is not a multiple of the access size raises `resp_err`. It causes no memory access, leaves memory unchanged and writes no register.
- R5: The low byte of `req_imm` selects the arithmetic: 0x00 add, 0x40 or, 0x50 and, 0xA0 xor. Each of these writes (old value op source), truncated to the access size, back to the address.
- R6: Bit 0 of `req_imm` is the fetch flag. For add, or, and and xor with the flag set, the response writes the old memory value to the source register. With the flag clear, the source register is not written.
- R7: Code 0xE1 (swap, fetch always set) stores the source value and returns the old memory value to the source register.
- R8: Code 0xF1 (compare-and-swap, fetch always set) stores the source value only when the old value equals register zero. When they differ, no write is issued. In both cases register zero receives the zero-extended old value, and the source register is not written.
- R9: Any other value of `req_imm` raises `resp_err`. This includes 0xE0, 0xF0 and any nonzero bit above bit 7. Such a request causes no memory access.
- R10: `req_ready` is high only when the unit is idle. Each accepted operation issues exactly one read, then at most one write, and no other request is taken until its response cycle has passed. After reset the unit is idle with no memory request.
- R11: The response is a single-cycle `resp_valid` pulse. It follows the last memory acknowledge, or follows acceptance directly for a rejected request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request taken at this edge |
| req_imm | input | 32 | Operation code with fetch flag in bit 0 |
| req_size | input | 2 | Access size code (2 = 32-bit, 3 = 64-bit) |
| req_base | input | 64 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_src | input | 64 | Source register value |
| req_r0 | input | 64 | Register zero value |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a write |
| mem_dw | output | 1 | Access is 64-bit (else 32-bit in the low lane) |
| mem_addr | output | 64 | Byte address |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | One-cycle acknowledge, read data valid with it |
| mem_rdata | input | 64 | Read data |
| resp_valid | output | 1 | Response cycle |
| resp_err | output | 1 | Request rejected |
| src_we | output | 1 | Write old value to the source register |
| src_wdata | output | 64 | Value for the source register |
| r0_we | output | 1 | Write old value to register zero |
| r0_wdata | output | 64 | Value for register zero |

## Verification
Two events can fall in the same cycle: the response of one operation, and a fresh request waiting to be taken. The bench raises every next request in the response cycle of the previous one. It then judges that `req_ready` is low there, that the waiting request is taken only one cycle later, and that its single read and optional write carry its own address and data. In the same way, the compare decision of compare-and-swap is made in the cycle the read data arrives. Hit and miss cases for both widths show whether the write is issued or skipped as the model predicts.

// File: rtl/amo_pkg.sv
package amo_pkg;

    localparam int XLEN   = 64;
    localparam int WORD_W = 32;
    localparam int OFF_W  = 16;
    localparam int IMM_W  = 32;
    localparam int CODE_W = 8;

    localparam logic [CODE_W-1:0] CODE_ADD   = 8'h00;
    localparam logic [CODE_W-1:0] CODE_OR    = 8'h40;
    localparam logic [CODE_W-1:0] CODE_AND   = 8'h50;
    localparam logic [CODE_W-1:0] CODE_XOR   = 8'hA0;
    localparam logic [CODE_W-1:0] CODE_SWAP  = 8'hE0;
    localparam logic [CODE_W-1:0] CODE_CAS   = 8'hF0;
    localparam logic [CODE_W-1:0] FETCH_FLAG = 8'h01;

    localparam logic [1:0] SIZE_WORD  = 2'd2;
    localparam logic [1:0] SIZE_DWORD = 2'd3;

    typedef enum logic [2:0] {
        OP_ADD, OP_OR, OP_AND, OP_XOR, OP_SWAP, OP_CAS
    } amo_op_e;

    typedef enum logic [1:0] {
        ST_IDLE, ST_READ, ST_WRITE, ST_RESP
    } amo_state_e;

    typedef struct packed {
        amo_op_e         op;
        logic            fetch;
        logic            dw;
        logic            err;
        logic [XLEN-1:0] addr;
    } amo_ctrl_t;

    function automatic logic [XLEN-1:0] size_mask(input logic dw);
        return dw ? {XLEN{1'b1}} : {{(XLEN-WORD_W){1'b0}}, {WORD_W{1'b1}}};
    endfunction

endpackage

// File: rtl/amo_decode.sv
module amo_decode
    import amo_pkg::*;
(
    input  logic [IMM_W-1:0] imm,
    input  logic [1:0]       size,
    input  logic [XLEN-1:0]  base,
    input  logic [OFF_W-1:0] offset,
    output amo_ctrl_t        ctrl
);
    logic            code_ok;
    logic            size_ok;
    logic            misaligned;
    logic [XLEN-1:0] addr;
    amo_op_e         op;
    logic            fetch;

    always_comb begin
        addr    = base + {{(XLEN-OFF_W){offset[OFF_W-1]}}, offset};
        size_ok = (size == SIZE_WORD) || (size == SIZE_DWORD);
        code_ok = 1'b1;
        fetch   = imm[0];
        op      = OP_ADD;
        unique case (imm[CODE_W-1:0])
            CODE_ADD, CODE_ADD | FETCH_FLAG: op = OP_ADD;
            CODE_OR,  CODE_OR  | FETCH_FLAG: op = OP_OR;
            CODE_AND, CODE_AND | FETCH_FLAG: op = OP_AND;
            CODE_XOR, CODE_XOR | FETCH_FLAG: op = OP_XOR;
            CODE_SWAP | FETCH_FLAG:          op = OP_SWAP;
            CODE_CAS  | FETCH_FLAG:          op = OP_CAS;
            default:                         code_ok = 1'b0;
        endcase
        if (|imm[IMM_W-1:CODE_W]) begin
            code_ok = 1'b0;
        end
        misaligned = (size == SIZE_DWORD) ? (|addr[2:0]) : (|addr[1:0]);

        ctrl.op    = op;
        ctrl.fetch = fetch;
        ctrl.dw    = (size == SIZE_DWORD);
        ctrl.err   = !size_ok || !code_ok || misaligned;
        ctrl.addr  = addr;
    end
endmodule

// File: rtl/amo_alu.sv
module amo_alu
    import amo_pkg::*;
(
    input  amo_op_e         op,
    input  logic            dw,
    input  logic [XLEN-1:0] old_val,
    input  logic [XLEN-1:0] src_val,
    input  logic [XLEN-1:0] r0_val,
    output logic [XLEN-1:0] new_val,
    output logic            cmp_hit
);
    logic [XLEN-1:0] mask;
    logic [XLEN-1:0] a;
    logic [XLEN-1:0] b;
    logic [XLEN-1:0] res;

    always_comb begin
        mask    = size_mask(dw);
        a       = old_val & mask;
        b       = src_val & mask;
        cmp_hit = (a == (r0_val & mask));
        unique case (op)
            OP_ADD:  res = a + b;
            OP_OR:   res = a | b;
            OP_AND:  res = a & b;
            OP_XOR:  res = a ^ b;
            OP_SWAP: res = b;
            OP_CAS:  res = b;
            default: res = b;
        endcase
        new_val = res & mask;
    end
endmodule

// File: rtl/amo_unit.sv
module amo_unit
    import amo_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [IMM_W-1:0] req_imm,
    input  logic [1:0]       req_size,
    input  logic [XLEN-1:0]  req_base,
    input  logic [OFF_W-1:0] req_offset,
    input  logic [XLEN-1:0]  req_src,
    input  logic [XLEN-1:0]  req_r0,
    output logic             mem_req,
    output logic             mem_we,
    output logic             mem_dw,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  mem_wdata,
    input  logic             mem_ack,
    input  logic [XLEN-1:0]  mem_rdata,
    output logic             resp_valid,
    output logic             resp_err,
    output logic             src_we,
    output logic [XLEN-1:0]  src_wdata,
    output logic             r0_we,
    output logic [XLEN-1:0]  r0_wdata
);
    amo_state_e      state_q;
    amo_ctrl_t       ctrl_d;
    amo_ctrl_t       ctrl_q;
    logic [XLEN-1:0] src_q;
    logic [XLEN-1:0] r0_q;
    logic [XLEN-1:0] old_q;
    logic [XLEN-1:0] alu_old;
    logic [XLEN-1:0] alu_new;
    logic            alu_hit;
    logic [XLEN-1:0] rd_masked;

    amo_decode u_decode (
        .imm    (req_imm),
        .size   (req_size),
        .base   (req_base),
        .offset (req_offset),
        .ctrl   (ctrl_d)
    );

    // The compare runs on the read data in the acknowledge cycle so a miss skips the write.
    assign rd_masked = mem_rdata & size_mask(ctrl_q.dw);
    assign alu_old   = (state_q == ST_READ) ? rd_masked : old_q;

    amo_alu u_alu (
        .op      (ctrl_q.op),
        .dw      (ctrl_q.dw),
        .old_val (alu_old),
        .src_val (src_q),
        .r0_val  (r0_q),
        .new_val (alu_new),
        .cmp_hit (alu_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ctrl_q  <= '0;
            src_q   <= '0;
            r0_q    <= '0;
            old_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        ctrl_q  <= ctrl_d;
                        src_q   <= req_src;
                        r0_q    <= req_r0;
                        state_q <= ctrl_d.err ? ST_RESP : ST_READ;
                    end
                end
                ST_READ: begin
                    if (mem_ack) begin
                        old_q   <= rd_masked;
                        state_q <= (ctrl_q.op == OP_CAS && !alu_hit) ? ST_RESP : ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (mem_ack) begin
                        state_q <= ST_RESP;
                    end
                end
                ST_RESP: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        mem_req    = (state_q == ST_READ) || (state_q == ST_WRITE);
        mem_we     = (state_q == ST_WRITE);
        mem_dw     = ctrl_q.dw;
        mem_addr   = ctrl_q.addr;
        mem_wdata  = alu_new;
        resp_valid = (state_q == ST_RESP);
        resp_err   = resp_valid && ctrl_q.err;
        src_we     = resp_valid && !ctrl_q.err && ctrl_q.fetch && (ctrl_q.op != OP_CAS);
        src_wdata  = old_q;
        r0_we      = resp_valid && !ctrl_q.err && (ctrl_q.op == OP_CAS);
        r0_wdata   = old_q;
    end
endmodule

// File: rtl/amo_checker.sv
module amo_checker
    import amo_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            req_ready,
    input logic            mem_req,
    input logic            mem_we,
    input logic [XLEN-1:0] mem_addr,
    input logic            resp_valid,
    input logic            resp_err,
    input logic            src_we,
    input logic            r0_we
);
    AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mem_req); // R10

    AST_READ_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) |-> !mem_we); // R10

    AST_BUSY_IN_RESP: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> !req_ready); // R10

    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid); // R11

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (mem_req && $past(mem_req)) |-> $stable(mem_addr)); // R1

    AST_ERR_NO_WB: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_err) |-> (!src_we && !r0_we)); // R4

    AST_CAS_NO_SRC: assert property (@(posedge clk) disable iff (rst)
        r0_we |-> !src_we); // R8
endmodule

bind amo_unit amo_checker u_amo_checker (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .resp_valid (resp_valid),
    .resp_err   (resp_err),
    .src_we     (src_we),
    .r0_we      (r0_we)
);

// File: tb/amo_unit_tb_top.sv
`timescale 1ns/1ps
module amo_unit_tb_top;
    import amo_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_imm = '0;
    logic [1:0]  req_size = '0;
    logic [63:0] req_base = '0;
    logic [15:0] req_offset = '0;
    logic [63:0] req_src = '0;
    logic [63:0] req_r0 = '0;
    logic        mem_req, mem_we, mem_dw;
    logic [63:0] mem_addr, mem_wdata;
    logic        mem_ack;
    logic [63:0] mem_rdata;
    logic        resp_valid, resp_err, src_we, r0_we;
    logic [63:0] src_wdata, r0_wdata;

    int n_chk = 0;
    int n_fail = 0;
    int n_rd = 0;
    int n_wr = 0;
    logic [63:0] mem_m [16];

    always #2.5 clk = ~clk;

    amo_unit dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_imm(req_imm), .req_size(req_size), .req_base(req_base),
        .req_offset(req_offset), .req_src(req_src), .req_r0(req_r0),
        .mem_req(mem_req), .mem_we(mem_we), .mem_dw(mem_dw), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .resp_valid(resp_valid), .resp_err(resp_err), .src_we(src_we),
        .src_wdata(src_wdata), .r0_we(r0_we), .r0_wdata(r0_wdata)
    );

    // Memory model: acknowledges one cycle after it sees a request.
    initial begin
        mem_ack   = 1'b0;
        mem_rdata = '0;
        forever begin
            @(posedge clk);
            if (mem_req && !mem_ack) begin
                mem_ack <= 1'b1;
                if (mem_we) begin
                    n_wr++;
                    if (mem_dw) mem_m[mem_addr[6:3]] <= mem_wdata;
                    else if (mem_addr[2]) mem_m[mem_addr[6:3]][63:32] <= mem_wdata[31:0];
                    else mem_m[mem_addr[6:3]][31:0] <= mem_wdata[31:0];
                end else begin
                    n_rd++;
                    if (mem_dw) mem_rdata <= mem_m[mem_addr[6:3]];
                    else if (mem_addr[2]) mem_rdata <= {32'h0, mem_m[mem_addr[6:3]][63:32]};
                    else mem_rdata <= {32'h0, mem_m[mem_addr[6:3]][31:0]};
                end
            end else begin
                mem_ack <= 1'b0;
            end
        end
    end

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R11 watchdog expired actual=hung expected=done");
        report();
        $finish;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Starts at a falling edge; the caller may be in the previous response cycle.
    task automatic issue(input logic [31:0] imm, input logic [1:0] size, input logic [63:0] base,
                         input logic [15:0] off, input logic [63:0] src, input logic [63:0] r0);
        logic rdy;
        req_imm = imm; req_size = size; req_base = base; req_offset = off;
        req_src = src; req_r0 = r0; req_valid = 1'b1;
        do begin
            rdy = req_ready;
            @(posedge clk);
            @(negedge clk);
        end while (!rdy);
        req_valid = 1'b0;
    endtask

    task automatic run_check(input string tag, input logic [31:0] imm, input logic [1:0] size,
                             input logic [63:0] base, input logic [15:0] off,
                             input logic [63:0] src, input logic [63:0] r0);
        logic [63:0] addr, mask, oldv, newv, word_before, word_after;
        logic        dw, err, code_ok, fetch_ret, is_cas, hit, do_wr;
        int          rd0, wr0, waited, busy_bad;
        logic [3:0]  idx;
        addr = base + {{48{off[15]}}, off};
        dw   = (size == 2'd3);
        mask = dw ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
        idx  = addr[6:3];
        code_ok = (imm[31:8] == 24'h0) &&
                  (imm[7:0] inside {8'h00, 8'h01, 8'h40, 8'h41, 8'h50, 8'h51,
                                    8'hA0, 8'hA1, 8'hE1, 8'hF1});
        err  = !(size inside {2'd2, 2'd3}) || !code_ok ||
               (dw ? (addr[2:0] != 0) : (addr[1:0] != 0));
        word_before = mem_m[idx];
        oldv = dw ? word_before : (addr[2] ? {32'h0, word_before[63:32]} : {32'h0, word_before[31:0]});
        is_cas = (imm[7:0] == 8'hF1);
        hit  = (oldv == (r0 & mask));
        case (imm[7:4])
            4'h0: newv = (oldv + src) & mask;
            4'h4: newv = (oldv | src) & mask;
            4'h5: newv = (oldv & src) & mask;
            4'hA: newv = (oldv ^ src) & mask;
            default: newv = src & mask;
        endcase
        do_wr = !err && (!is_cas || hit);
        fetch_ret = !err && imm[0] && !is_cas;
        word_after = word_before;
        if (do_wr) begin
            if (dw) word_after = newv;
            else if (addr[2]) word_after[63:32] = newv[31:0];
            else word_after[31:0] = newv[31:0];
        end
        rd0 = n_rd; wr0 = n_wr;
        issue(imm, size, base, off, src, r0);
        waited = 0; busy_bad = 0;
        while (!resp_valid && waited < 50) begin
            if (req_ready) busy_bad++;
            @(negedge clk);
            waited++;
        end
        chk({tag, " R11 response pulse"}, resp_valid, 1'b1);
        chk({tag, " R10 ready low while busy and in response"}, busy_bad + req_ready, 0);
        chk({tag, " R3 R4 R9 error flag"}, resp_err, err);
        chk({tag, " R6 R7 source write enable"}, src_we, fetch_ret);
        if (fetch_ret) chk({tag, " R2 R6 R7 source value"}, src_wdata, oldv);
        chk({tag, " R8 register zero write enable"}, r0_we, !err && is_cas);
        if (!err && is_cas) chk({tag, " R8 register zero value"}, r0_wdata, oldv);
        chk({tag, " R1 R2 R5 memory word"}, mem_m[idx], word_after);
        chk({tag, " R10 read count"}, n_rd - rd0, err ? 0 : 1);
        chk({tag, " R8 R10 write count"}, n_wr - wr0, do_wr ? 1 : 0);
    endtask

    localparam logic [7:0] CODES [10] = '{8'h00, 8'h01, 8'h40, 8'h41, 8'h50, 8'h51,
                                          8'hA0, 8'hA1, 8'hE1, 8'hF1};

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 reset ready", req_ready, 1'b1);
        chk("R10 reset no mem request", mem_req, 1'b0);
        chk("R11 reset no response", resp_valid, 1'b0);
        rst = 1'b0;
        for (int i = 0; i < 16; i++) mem_m[i] = 64'h1111_0000_0000_0000 * i + 64'h0F0F;
        @(negedge clk);

        // R1 R2 R5 R6 R7 R8: sweep of every code, both widths, four patterns
        for (int c = 0; c < 10; c++) begin
            for (int s = 2; s <= 3; s++) begin
                for (int p = 0; p < 4; p++) begin
                    logic [63:0] base, pre, src, r0, oldv, addr;
                    logic [15:0] off;
                    base = 64'h0000_0000_0000_0240;
                    off  = (s == 3) ? 16'(p * 8 - 16) : 16'(p * 4 - 8);
                    addr = base + {{48{off[15]}}, off};
                    case (p)
                        0: begin pre = 64'hFFFF_FFFF_FFFF_FFFF; src = 64'h1; end
                        1: begin pre = 64'h0123_4567_89AB_CDEF; src = 64'hF0F0_0F0F_A5A5_5A5A; end
                        2: begin pre = 64'h8000_0000_7FFF_FFFF; src = 64'h8000_0000_8000_0001; end
                        default: begin pre = 64'hDEAD_BEEF_CAFE_F00D; src = 64'h0; end
                    endcase
                    mem_m[addr[6:3]] = pre;
                    oldv = (s == 3) ? pre : (addr[2] ? {32'h0, pre[63:32]} : {32'h0, pre[31:0]});
                    // even patterns hit in compare-and-swap, odd ones miss; upper half of r0 is junk
                    r0 = (p % 2 == 0) ? (oldv ^ ((s == 3) ? 64'h0 : 64'hABCD_0000_0000_0000))
                                      : (oldv ^ 64'h10);
                    run_check($sformatf("R5 sweep code=%h size=%0d pat=%0d", CODES[c], s, p),
                              {24'h0, CODES[c]}, 2'(s), base, off, src, r0);
                end
            end
        end

        // R3: bad size codes
        run_check("R3 size 0", 32'h01, 2'd0, 64'h100, 16'h0, 64'h5, 64'h0);
        run_check("R3 size 1", 32'hA0, 2'd1, 64'h100, 16'h0, 64'h5, 64'h0);
        // R4: misaligned addresses
        run_check("R4 dword off 4", 32'h01, 2'd3, 64'h100, 16'h4, 64'h5, 64'h0);
        run_check("R4 dword base odd", 32'hE1, 2'd3, 64'h101, 16'h0, 64'h5, 64'h0);
        run_check("R4 word off 2", 32'hF1, 2'd2, 64'h100, 16'h2, 64'h5, 64'h0);
        // R9: unknown codes
        run_check("R9 swap without fetch", 32'hE0, 2'd3, 64'h100, 16'h0, 64'h5, 64'h0);
        run_check("R9 cas without fetch", 32'hF0, 2'd3, 64'h100, 16'h0, 64'h5, 64'h0);
        run_check("R9 code 0x10", 32'h10, 2'd2, 64'h100, 16'h0, 64'h5, 64'h0);
        run_check("R9 upper bits", 32'h0000_0100, 2'd3, 64'h100, 16'h0, 64'h5, 64'h0);
        // R1: negative displacement crossing below the base
        mem_m[4'h2] = 64'h0000_0000_0000_0010;
        run_check("R1 negative offset", 32'h01, 2'd3, 64'h0000_0000_0001_0030, 16'hFFE0,
                  64'h22, 64'h0);
        // R10 R11: error right after a good one, and good right after error
        run_check("R10 good then error", 32'h41, 2'd2, 64'h104, 16'h0, 64'h3, 64'h0);
        run_check("R10 error then good", 32'h33, 2'd2, 64'h104, 16'h0, 64'h3, 64'h0);
        run_check("R10 follow-up", 32'h51, 2'd2, 64'h104, 16'h0, 64'h3, 64'h0);

        @(negedge clk);
        report();
        $finish;
    end
endmodule